// File: doc/BRIEF.md
# Single-Source NMI Trigger Controller

This block watches one external non-maskable interrupt pin and turns qualifying activity on it into a single interrupt request to a parent controller. Software picks one of four trigger modes: low level, high level, falling edge or rising edge. Each qualifying event sets a sticky pending flag, and software clears that flag by writing one to it. The request output is raised while the pending flag and the enable flag are both set.

The pin is asynchronous. It passes through a two-flop synchronizer, and the last synchronized sample is kept so that edges can be found. Detection is held off after reset until the synchronizer and the history flop hold real pin samples. A level that is still active keeps setting the pending flag, so a clear only takes effect once the level has gone away.

Software reaches the block through a flat register port. The port has an address, a write strobe and write data, and read data that follows the address combinationally. A build parameter picks one of three address layouts. Only the offsets change between layouts; the function is the same. Every port is plain control or status. No path carries streamed data, so none of the ports has a valid/ready handshake.

Top module: `nmi_trig_ctrl`

## Requirements
- R1: After reset the mode, pending and enable registers all read 0, and `irq_out` is 0.
- R2: The mode register keeps all 32 written bits and reads them back unchanged. Its bits [1:0] select the trigger: 0 low level, 1 falling edge, 2 high level, 3 rising edge. Rewriting the register with new [1:0] and the previously read upper bits leaves the upper bits as they were.
- R3: In low-level mode, pending is set on every cycle the synchronized pin is 0. A clear written while the pin is still low is overridden, so pending reads 1 again.
- R4: In high-level mode, pending is set on every cycle the synchronized pin is 1. A clear written while the pin is high is overridden.
- R5: In falling-edge mode, one 1-to-0 transition sets pending once. After a clear, pending stays 0 while the pin holds low, and a 0-to-1 transition does not set it.
- R6: In rising-edge mode, only a 0-to-1 transition sets pending. A 1-to-0 transition does not set it.
- R7: Writing 1 to bit 0 of the pending register clears it. Writing 0 leaves it unchanged.
- R8: Bit 0 of the enable register gates the output. `irq_out` is a register loaded with pending AND enable, so it follows a change of either one a cycle later. It stays 0 while enable is 0.
- R9: Address layout, chosen by `LAYOUT`. Layout 0: mode 0x00, pending 0x04, enable 0x34. Layout 1: mode 0x00, pending 0x04, enable 0x08. Layout 2: mode 0x00, enable 0x04, pending 0x08. Any other offset reads 0, and writes to it change nothing.
- R10: A pin change reaches the pending register on the third rising clock edge after it is applied: two synchronizer stages, then the pending flop.
- R11: If a qualifying event and a pending clear arrive in the same cycle, the event wins and pending ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Asynchronous external interrupt pin |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, taken at the rising clock edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
The hardest case to reach is a pending clear that lands in exactly the cycle a single edge event fires. There the event has to win, and a one-cycle slip on either side hides the fault. The stimulus changes the pin, counts two falling clock edges so that the synchronized edge is due at the third rising edge, and times the clear write so that it commits on that same edge. Level-mode overrides are reached by writing the clear while the pin is still held at its active level.

// File: rtl/nmi_trig_pkg.sv
package nmi_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic [7:0] mode_off;
    logic [7:0] pend_off;
    logic [7:0] en_off;
  } reg_map_t;

  // Offset set for each supported layout; unknown selections fall back to layout 1.
  function automatic reg_map_t layout_map(input int unsigned sel);
    reg_map_t m;
    case (sel)
      0:       m = '{mode_off: 8'h00, pend_off: 8'h04, en_off: 8'h34};
      2:       m = '{mode_off: 8'h00, pend_off: 8'h08, en_off: 8'h04};
      default: m = '{mode_off: 8'h00, pend_off: 8'h04, en_off: 8'h08};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic cur_q,
  output logic prev_q,
  output logic primed
);
  localparam int unsigned WARM  = STAGES + 1;
  localparam int unsigned CNT_W = $clog2(WARM + 1);

  logic [STAGES-1:0] chain_q;
  logic [CNT_W-1:0]  warm_q;
  logic              hist_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= pin_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      warm_q <= '0;
    end else begin
      hist_q <= chain_q[STAGES-1];
      if (warm_q != CNT_W'(WARM)) warm_q <= warm_q + 1'b1;
    end
  end

  assign cur_q  = chain_q[STAGES-1];
  assign prev_q = hist_q;
  assign primed = (warm_q == CNT_W'(WARM));

  AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed); // R10

endmodule

// File: rtl/nmi_trig_detect.sv
module nmi_trig_detect
  import nmi_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       cur,
  input  logic       prev,
  input  logic       primed,
  output logic       evt
);
  logic hit;

  always_comb begin
    unique case (mode)
      TRIG_LVL_LO:    hit = ~cur;
      TRIG_EDGE_FALL: hit = prev & ~cur;
      TRIG_LVL_HI:    hit = cur;
      TRIG_EDGE_RISE: hit = ~prev & cur;
      default:        hit = 1'b0;
    endcase
  end

  assign evt = primed & hit;

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == TRIG_EDGE_FALL || mode == TRIG_EDGE_RISE) && evt)
      |=> (!evt || !$stable(mode))); // R5

endmodule

// File: rtl/nmi_trig_regs.sv
module nmi_trig_regs
  import nmi_trig_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LAYOUT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt,
  output trig_mode_e        mode,
  output logic              pending,
  output logic              enable
);
  localparam reg_map_t MAP = layout_map(LAYOUT);

  logic [DATA_W-1:0] mode_q;
  logic              pend_q;
  logic              en_q;
  logic              hit_mode, hit_pend, hit_en, clr;

  assign hit_mode = (reg_addr == ADDR_W'(MAP.mode_off));
  assign hit_pend = (reg_addr == ADDR_W'(MAP.pend_off));
  assign hit_en   = (reg_addr == ADDR_W'(MAP.en_off));
  assign clr      = reg_wr & hit_pend & reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= 1'b0;
    end else if (reg_wr) begin
      if (hit_mode) mode_q <= reg_wdata;
      if (hit_en)   en_q   <= reg_wdata[0];
    end
  end

  // Detection outranks a software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (evt) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_mode)      reg_rdata = mode_q;
    else if (hit_pend) reg_rdata = DATA_W'(pend_q);
    else if (hit_en)   reg_rdata = DATA_W'(en_q);
  end

  assign mode    = trig_mode_e'(mode_q[1:0]);
  assign pending = pend_q;
  assign enable  = en_q;

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pending); // R11
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !pending); // R7
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !clr) |=> $stable(pending)); // R7

endmodule

// File: rtl/nmi_trig_ctrl.sv
module nmi_trig_ctrl
  import nmi_trig_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned LAYOUT      = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  logic       s_cur, s_prev, s_primed, evt, pending, enable, irq_q;
  trig_mode_e mode;

  nmi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(nmi_pin),
    .cur_q(s_cur), .prev_q(s_prev), .primed(s_primed)
  );

  nmi_trig_detect u_detect (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .cur(s_cur), .prev(s_prev), .primed(s_primed), .evt(evt)
  );

  nmi_trig_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LAYOUT(LAYOUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
    .mode(mode), .pending(pending), .enable(enable)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending & enable;

  assign irq_out = irq_q;

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !irq_out); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(pending)); // R8

endmodule

// File: tb/nmi_trig_ctrl_test.sv
`timescale 1ns/1ps
module nmi_trig_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_pin = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_b, rdata_a, rdata_c;
  logic        irq_b, irq_a, irq_c;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int          src_q[$];
  logic [31:0] exp_q[$];
  string       req_q[$];
  event        sample_ev;

  always #4 clk = ~clk;

  nmi_trig_ctrl #(.LAYOUT(1)) uut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .irq_out(irq_b));
  nmi_trig_ctrl #(.LAYOUT(0)) uut_a (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .irq_out(irq_a));
  nmi_trig_ctrl #(.LAYOUT(2)) uut_c (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata_c), .irq_out(irq_c));

  // Monitor: pops expected items and compares with the selected output.
  always @(sample_ev) begin
    #1;
    while (exp_q.size() > 0) begin
      int          s;
      logic [31:0] e, act;
      string       r;
      s = src_q.pop_front();
      e = exp_q.pop_front();
      r = req_q.pop_front();
      case (s)
        0:       act = rdata_b;
        1:       act = {31'd0, irq_b};
        2:       act = rdata_a;
        default: act = rdata_c;
      endcase
      checks++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", r, act, e);
      end
    end
  end

  task automatic chk(input int src, input logic [7:0] addr,
                     input logic [31:0] e, input string r);
    @(negedge clk);
    reg_addr = addr;
    src_q.push_back(src);
    exp_q.push_back(e);
    req_q.push_back(r);
    -> sample_ev;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = addr;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk);
    nmi_pin = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1 reset state, R9 unmapped offsets
    chk(0, 8'h00, 32'h0, "R1 mode reset");
    chk(0, 8'h04, 32'h0, "R1 pending reset");
    chk(0, 8'h08, 32'h0, "R1 enable reset");
    chk(1, 8'h00, 32'h0, "R1 irq reset");
    chk(0, 8'h0C, 32'h0, "R9 unmapped 0x0C");
    chk(0, 8'hFC, 32'h0, "R9 unmapped 0xFC");
    // R9 layouts
    wr(8'h34, 32'h1);
    chk(2, 8'h34, 32'h1, "R9 layout0 enable at 0x34");
    chk(0, 8'h34, 32'h0, "R9 layout1 0x34 unmapped");
    chk(3, 8'h34, 32'h0, "R9 layout2 0x34 unmapped");
    chk(2, 8'h08, 32'h0, "R9 layout0 0x08 unmapped");
    wr(8'h04, 32'h1);
    chk(3, 8'h04, 32'h1, "R9 layout2 enable at 0x04");
    chk(3, 8'h08, 32'h0, "R9 layout2 pending at 0x08");
    chk(0, 8'h04, 32'h0, "R9 layout1 pending at 0x04");
    wr(8'h08, 32'h0);
    // R2 mode register, low level first
    wr(8'h00, 32'hA5A5_0000);
    chk(0, 8'h00, 32'hA5A5_0000, "R2 mode readback");
    // R10 latency, R3 low level
    pin_set(1'b0);
    idle(1);
    chk(0, 8'h04, 32'h0, "R10 pending not yet set");
    chk(0, 8'h04, 32'h1, "R10 R3 pending on third edge");
    chk(1, 8'h00, 32'h0, "R8 masked irq");
    wr(8'h08, 32'h1);
    chk(1, 8'h00, 32'h0, "R8 irq one cycle later");
    chk(1, 8'h00, 32'h1, "R8 irq raised");
    wr(8'h04, 32'h1);
    chk(0, 8'h04, 32'h1, "R3 clear overridden while low");
    pin_set(1'b1);
    idle(3);
    wr(8'h04, 32'h1);
    chk(0, 8'h04, 32'h0, "R7 write one clears");
    idle(2);
    chk(0, 8'h04, 32'h0, "R3 stays clear once high");
    chk(1, 8'h00, 32'h0, "R8 irq drops");
    // R5 falling edge
    wr(8'h00, 32'hA5A5_0001);
    chk(0, 8'h00, 32'hA5A5_0001, "R2 upper bits kept");
    pin_set(1'b0);
    idle(4);
    chk(0, 8'h04, 32'h1, "R5 falling edge sets");
    wr(8'h04, 32'h0);
    chk(0, 8'h04, 32'h1, "R7 write zero no effect");
    wr(8'h04, 32'h1);
    idle(3);
    chk(0, 8'h04, 32'h0, "R5 single event while low");
    pin_set(1'b1);
    idle(4);
    chk(0, 8'h04, 32'h0, "R5 rising ignored");
    // R6 rising edge
    wr(8'h00, 32'hA5A5_0003);
    pin_set(1'b0);
    idle(4);
    chk(0, 8'h04, 32'h0, "R6 falling ignored");
    pin_set(1'b1);
    idle(4);
    chk(0, 8'h04, 32'h1, "R6 rising edge sets");
    chk(1, 8'h00, 32'h1, "R8 irq on rising event");
    wr(8'h04, 32'h1);
    idle(2);
    chk(0, 8'h04, 32'h0, "R6 clear holds");
    // R11 clear in the same cycle as an edge event
    pin_set(1'b0);
    idle(4);
    pin_set(1'b1);
    idle(1);
    wr(8'h04, 32'h1);
    chk(0, 8'h04, 32'h1, "R11 event beats clear");
    wr(8'h04, 32'h1);
    chk(0, 8'h04, 32'h0, "R11 later clear works");
    // R4 high level
    wr(8'h00, 32'hA5A5_0002);
    idle(1);
    chk(0, 8'h04, 32'h1, "R4 high level sets");
    wr(8'h04, 32'h1);
    chk(0, 8'h04, 32'h1, "R4 clear overridden while high");
    pin_set(1'b0);
    idle(3);
    wr(8'h04, 32'h1);
    idle(2);
    chk(0, 8'h04, 32'h0, "R4 clear after level gone");
    // R8 masking
    pin_set(1'b1);
    idle(4);
    chk(1, 8'h00, 32'h1, "R8 irq with level high");
    wr(8'h08, 32'h0);
    chk(1, 8'h00, 32'h1, "R8 mask takes a cycle");
    chk(1, 8'h00, 32'h0, "R8 masked output");
    chk(0, 8'h08, 32'h0, "R8 enable reads 0");
    chk(0, 8'h04, 32'h1, "R8 pending kept while masked");
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule